// File: doc/BRIEF.md
# Strap-Configured Host Register Bus Slave

This block lets an 8-bit host processor read and write a bank of byte-wide registers over a 12-bit address space. Two strap inputs, which are held static while the chip runs, set its bus personality. The mux strap picks one of two address arrangements. In one, all twelve address bits arrive on dedicated pins. In the other, the low byte is shared with the data lines and is captured at the start of each access. The style strap picks one of two control sets. The first uses a data strobe, a read/write level and an active-low acknowledge. The second uses separate read and write strobes and an active-high ready.

The block decodes chip select and the strobes, and holds the address steady through each access. It drives the shared data lines only during a selected read. A write commits when its strobe ends. One pin gives the handshake for both control styles. It can hold the host for a parameter-set number of interface-clock cycles, for hosts too fast to run without wait states. A small register file stands in for the logic that would sit behind the bus.

Top module: `hostbus_slave`

## Requirements
- R1: With `style_strap`=0 an access is a read when `cs_n`=0, `ds_rd_n`=0 and `rw_wr_n`=1, and a write when `cs_n`=0, `ds_rd_n`=0 and `rw_wr_n`=0. With `style_strap`=1 a read is `cs_n`=0 with `ds_rd_n`=0, and a write is `cs_n`=0 with `rw_wr_n`=0.
- R2: With `mux_strap`=0 the register address is `addr_pins[11:0]`. The address strobe/latch input and any value on `ad` during the address phase have no effect.
- R3: With `mux_strap`=1, address bits 7:0 are captured from `ad` on each clock edge where `cs_n`=0, no read or write is active, and the address strobe is active. The address strobe is `as_ale`=0 in style 0 and `as_ale`=1 in style 1. Address bits 11:8 come from `addr_pins[11:8]`, and `addr_pins[7:0]` is ignored.
- R4: A write commits on the first clock edge at which the write condition is no longer true. It uses the address and the `ad` value sampled on the last edge at which the write was active. A new address phase that starts at that same edge does not disturb the commit.
- R5: Only offsets `REG_BASE` to `REG_BASE+NUM_REGS-1` (default 0x000 to 0x00F) are defined. A write to any other address changes no register, including registers whose low address bits match. A read of any other address returns 0x00.
- R6: `ad` is driven only while the R1 read condition holds. At all other times it is high-impedance.
- R7: During a read, `ad` shows the register at the current address without waiting for a clock edge.
- R8: With `style_strap`=0, `ack_rdy` is an active-low acknowledge. It is low only after a read or write has been active for `WAIT_CYCLES` clock edges, and it is high when idle.
- R9: With `style_strap`=1, `ack_rdy` is an active-high ready. It is low only during the first `WAIT_CYCLES` clock edges of an active read or write, and it is high otherwise.
- R10: After a synchronous active-low reset every register reads 0x00, `ad` is high-impedance and `ack_rdy` is high.
- R11: Strobes given while `cs_n`=1 neither write a register nor drive `ad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| style_strap | input | 1 | Control style: 0 strobe + R/W + acknowledge, 1 read/write strobes + ready |
| mux_strap | input | 1 | 0 separate address pins, 1 low address byte shared on `ad` |
| cs_n | input | 1 | Chip select, active low |
| as_ale | input | 1 | Address strobe (active low, style 0) or latch enable (active high, style 1) |
| ds_rd_n | input | 1 | Data strobe (style 0) or read strobe (style 1), active low |
| rw_wr_n | input | 1 | Read/write level (1 = read, style 0) or write strobe (active low, style 1) |
| addr_pins | input | 12 | Dedicated address pins; only bits 11:8 are used when multiplexed |
| ad | inout | 8 | Shared address/data lines |
| ack_rdy | output | 1 | Acknowledge (style 0) or ready (style 1) handshake |

## Verification
A write commit and the address capture for the next access can land on the same clock edge. In the multiplexed read/write-strobe mode the host releases the write strobe and, at that same edge, raises the latch enable with a new address on `ad`. The bench provokes this without dropping chip select, then reads both addresses. It expects the old address to hold the written byte and the new address to keep its earlier contents. The bench also reads the new address at once, to confirm the capture was not skipped.

// File: rtl/hbs_pkg.sv
// Package: shared types for the host register bus slave.
// Assumes: straps are static during operation.
package hbs_pkg;
    typedef enum logic {
        STYLE_STROBE = 1'b0,
        STYLE_RDWR   = 1'b1
    } ctl_style_e;

    typedef struct packed {
        logic rd;       // selected read active
        logic wr;       // selected write active
        logic addr_ph;  // selected address phase (strobe active, no data phase)
    } bus_req_t;
endpackage

// File: rtl/hbs_decode.sv
// Module: hbs_decode
// Turns raw pin levels into normalised read/write/address-phase requests
// for either control style. Purely combinational; assumes pins are
// already synchronous to clk.
module hbs_decode
    import hbs_pkg::*;
(
    input  logic     style,
    input  logic     cs_n,
    input  logic     as_ale,
    input  logic     ds_rd_n,
    input  logic     rw_wr_n,
    output bus_req_t req
);
    logic sel;
    assign sel = ~cs_n;

    // Purpose: map control pins of the selected style onto one request form.
    always_comb begin
        req = '0;
        if (ctl_style_e'(style) == STYLE_STROBE) begin
            req.rd      = sel & ~ds_rd_n &  rw_wr_n;
            req.wr      = sel & ~ds_rd_n & ~rw_wr_n;
            req.addr_ph = sel & ~as_ale  &  ds_rd_n;
        end else begin
            req.rd      = sel & ~ds_rd_n;
            req.wr      = sel & ~rw_wr_n;
            req.addr_ph = sel &  as_ale & ds_rd_n & rw_wr_n;
        end
    end
endmodule

// File: rtl/hbs_capture.sv
// Module: hbs_capture
// Holds the shared-bus low address byte, forms the current address for
// either bus arrangement, registers write address/data and emits a
// one-cycle commit when the write condition ends.
// Assumes AW > DW.
module hbs_capture #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mux_sel,
    input  logic          addr_ph,
    input  logic          wr,
    input  logic [AW-1:0] addr_pins,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] lo_q,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] wa_q,
    output logic [DW-1:0] wd_q,
    output logic          commit
);
    logic wr_q;

    // Purpose: capture low address byte during a multiplexed address phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (mux_sel && addr_ph)
            lo_q <= ad_in;
    end

    // Purpose: select address source for the strapped arrangement.
    always_comb begin
        if (mux_sel)
            cur_addr = {addr_pins[AW-1:DW], lo_q};
        else
            cur_addr = addr_pins;
    end

    // Purpose: track write address/data while writing and remember last state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wa_q <= '0;
            wd_q <= '0;
            wr_q <= 1'b0;
        end else begin
            wr_q <= wr;
            if (wr) begin
                wa_q <= cur_addr;
                wd_q <= ad_in;
            end
        end
    end

    assign commit = wr_q & ~wr;
endmodule

// File: rtl/hbs_wait.sv
// Module: hbs_wait
// Counts clock edges of an active access and drives the shared
// acknowledge/ready pin. With WAIT=0 no counter is built and the pin
// follows the strobes combinationally.
module hbs_wait
    import hbs_pkg::*;
#(
    parameter int WAIT = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic style,
    input  logic acc,
    output logic ack_rdy
);
    localparam int CW = (WAIT < 1) ? 1 : $clog2(WAIT + 1);

    logic done;

    generate
        if (WAIT == 0) begin : g_nowait
            assign done = 1'b1;
        end else begin : g_wait
            logic [CW-1:0] cnt_q;
            // Purpose: saturating count of edges seen in the current access.
            always_ff @(posedge clk) begin
                if (!rst_n || !acc)
                    cnt_q <= '0;
                else if (cnt_q < CW'(WAIT))
                    cnt_q <= cnt_q + 1'b1;
            end
            assign done = (cnt_q >= CW'(WAIT));
        end
    endgenerate

    // Purpose: encode handshake polarity for the strapped style.
    always_comb begin
        if (ctl_style_e'(style) == STYLE_STROBE)
            ack_rdy = ~(acc & done);
        else
            ack_rdy = ~(acc & ~done);
    end
endmodule

// File: rtl/hbs_regfile.sv
// Module: hbs_regfile
// Test register bank of NUM byte registers at offsets BASE..BASE+NUM-1.
// Writes outside the window are dropped; reads outside return zero.
module hbs_regfile #(
    parameter int AW   = 12,
    parameter int DW   = 8,
    parameter int BASE = 0,
    parameter int NUM  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] regs [NUM];
    logic [AW-1:0] woff;
    logic [AW-1:0] roff;

    assign woff = wa - AW'(BASE);
    assign roff = ra - AW'(BASE);

    generate
        for (genvar i = 0; i < NUM; i++) begin : g_reg
            // Purpose: one register, loaded on a commit to its own offset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (we && woff == AW'(i))
                    regs[i] <= wd;
            end
        end
    endgenerate

    // Purpose: combinational read with zero for unmapped offsets.
    always_comb begin
        rd = '0;
        for (int i = 0; i < NUM; i++)
            if (roff == AW'(i))
                rd = regs[i];
    end
endmodule

// File: rtl/hostbus_slave.sv
// Module: hostbus_slave (top)
// Strap-configured host bus slave: decodes four bus personalities,
// drives the shared data lines on reads, commits writes at strobe end
// and drives one acknowledge/ready pin with optional wait states.
// Assumes all control pins are synchronous to clk and straps are static.
module hostbus_slave #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 8,
    parameter int REG_BASE    = 0,
    parameter int NUM_REGS    = 16,
    parameter int WAIT_CYCLES = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              style_strap,
    input  logic              mux_strap,
    input  logic              cs_n,
    input  logic              as_ale,
    input  logic              ds_rd_n,
    input  logic              rw_wr_n,
    input  logic [ADDR_W-1:0] addr_pins,
    inout  wire  [DATA_W-1:0] ad,
    output logic              ack_rdy
);
    import hbs_pkg::*;

    bus_req_t          req;
    logic              acc;
    logic              ad_oe;
    logic              commit;
    logic [DATA_W-1:0] ad_in;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] addr_lo_q;
    logic [DATA_W-1:0] wd_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] wa_q;

    assign ad_in = ad;
    assign acc   = req.rd | req.wr;
    assign ad_oe = req.rd;
    assign ad    = ad_oe ? rd_data : 'z;

    hbs_decode u_dec (
        .style   (style_strap),
        .cs_n    (cs_n),
        .as_ale  (as_ale),
        .ds_rd_n (ds_rd_n),
        .rw_wr_n (rw_wr_n),
        .req     (req)
    );

    hbs_capture #(.AW(ADDR_W), .DW(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .mux_sel   (mux_strap),
        .addr_ph   (req.addr_ph),
        .wr        (req.wr),
        .addr_pins (addr_pins),
        .ad_in     (ad_in),
        .lo_q      (addr_lo_q),
        .cur_addr  (cur_addr),
        .wa_q      (wa_q),
        .wd_q      (wd_q),
        .commit    (commit)
    );

    hbs_wait #(.WAIT(WAIT_CYCLES)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .style   (style_strap),
        .acc     (acc),
        .ack_rdy (ack_rdy)
    );

    hbs_regfile #(.AW(ADDR_W), .DW(DATA_W), .BASE(REG_BASE), .NUM(NUM_REGS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .wa    (wa_q),
        .wd    (wd_q),
        .ra    (cur_addr),
        .rd    (rd_data)
    );
endmodule

// File: rtl/hostbus_slave_chk.sv
// Module: hostbus_slave_chk
// Assertion checker bound into hostbus_slave. It recomputes access
// conditions from the pins and compares them with internal controls.
module hostbus_slave_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          style_strap,
    input logic          mux_strap,
    input logic          cs_n,
    input logic          ds_rd_n,
    input logic          rw_wr_n,
    input logic          ad_oe,
    input logic          ack_rdy,
    input logic          commit,
    input logic          wr_act,
    input logic          acc,
    input logic [DW-1:0] lo_q
);
    logic pin_rd;
    assign pin_rd = ~cs_n & ~ds_rd_n & (style_strap | rw_wr_n);

    // R6 / R11: data lines enabled only during a selected read
    a_r6_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_rd |-> !ad_oe);

    // R4: commit only on the edge after the write condition ends
    a_r4_commit_at_strobe_end: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(wr_act) && !wr_act));

    // R11: a commit requires chip select in the previous cycle
    a_r11_commit_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(!cs_n));

    // R8: acknowledge high while deselected in strobe style
    a_r8_ack_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!style_strap && cs_n) |-> ack_rdy);

    // R9: ready high while deselected in read/write-strobe style
    a_r9_ready_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (style_strap && cs_n) |-> ack_rdy);

    // R3: captured low address byte holds through an access
    a_r3_addr_stable_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_strap && acc) |=> (!acc || $stable(lo_q)));
endmodule

bind hostbus_slave hostbus_slave_chk #(.DW(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .style_strap (style_strap),
    .mux_strap   (mux_strap),
    .cs_n        (cs_n),
    .ds_rd_n     (ds_rd_n),
    .rw_wr_n     (rw_wr_n),
    .ad_oe       (ad_oe),
    .ack_rdy     (ack_rdy),
    .commit      (commit),
    .wr_act      (req.wr),
    .acc         (acc),
    .lo_q        (addr_lo_q)
);

// File: tb/hostbus_slave_test.sv
// Directed bench for hostbus_slave, run with two wait states.
module hostbus_slave_test;
    localparam int W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        style = 1'b0;
    logic        mux = 1'b0;
    logic        cs_n = 1'b1;
    logic        as_ale = 1'b1;
    logic        ds_rd_n = 1'b1;
    logic        rw_wr_n = 1'b1;
    logic [11:0] apins = '0;
    logic [7:0]  tb_ad = '0;
    logic        tb_drv = 1'b0;
    wire  [7:0]  ad;
    wire         ack_rdy;
    int          n_run = 0;
    int          n_fail = 0;

    assign ad = tb_drv ? tb_ad : 8'hzz;

    always #5 clk = ~clk;

    hostbus_slave #(.WAIT_CYCLES(W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .style_strap (style),
        .mux_strap   (mux),
        .cs_n        (cs_n),
        .as_ale      (as_ale),
        .ds_rd_n     (ds_rd_n),
        .rw_wr_n     (rw_wr_n),
        .addr_pins   (apins),
        .ad          (ad),
        .ack_rdy     (ack_rdy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // idle levels; in style 0 demux the address strobe is tied low
    task automatic set_idle();
        cs_n = 1'b1; tb_drv = 1'b0; ds_rd_n = 1'b1; rw_wr_n = 1'b1;
        as_ale = style ? 1'b0 : (mux ? 1'b1 : 1'b0);
    endtask

    task automatic apply_mode(input logic s, input logic m);
        @(negedge clk);
        style = s; mux = m; set_idle(); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // address phase; in demux, junk on ad and the strobe must be ignored
    task automatic start_addr(input logic [11:0] a);
        @(negedge clk);
        cs_n = 1'b0;
        apins = mux ? {a[11:8], ~a[7:0]} : a;
        tb_drv = 1'b1;
        tb_ad = mux ? a[7:0] : ~a[7:0];
        as_ale = style ? 1'b1 : 1'b0;
        @(negedge clk);
        if (style) as_ale = 1'b0;
        tb_drv = 1'b0;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        start_addr(a);
        tb_ad = d; tb_drv = 1'b1;
        if (style) rw_wr_n = 1'b0;
        else begin rw_wr_n = 1'b0; ds_rd_n = 1'b0; end
        repeat (W + 1) @(negedge clk);
        if (style) rw_wr_n = 1'b1; else ds_rd_n = 1'b1;
        @(negedge clk);
        set_idle();
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [7:0] exp, input string req);
        start_addr(a);
        rw_wr_n = 1'b1; ds_rd_n = 1'b0;
        #1;
        chk(req, ad, exp);
        chk(style ? "R9 ready low in wait" : "R8 ack high in wait", {7'd0, ack_rdy}, style ? 8'h00 : 8'h01);
        repeat (W) @(negedge clk);
        #1;
        chk(style ? "R9 ready after wait" : "R8 ack after wait", {7'd0, ack_rdy}, style ? 8'h01 : 8'h00);
        @(negedge clk);
        ds_rd_n = 1'b1;
        #1;
        chk("R6 hiz after read", ad, 8'hzz);
        @(negedge clk);
        set_idle();
    endtask

    task automatic t_reset();
        apply_mode(1'b0, 1'b0);
        #1;
        chk("R10 ad hiz", ad, 8'hzz);
        chk("R10 ack idle", {7'd0, ack_rdy}, 8'h01);
        bus_read(12'h004, 8'h00, "R10 reg cleared");
    endtask

    task automatic t_mode(input logic s, input logic m);
        apply_mode(s, m);
        bus_write(12'h003, 8'hA5);
        bus_write(12'h00F, 8'h3C);
        bus_read(12'h003, 8'hA5, "R1 R2 R4 R7 read back 0x003");
        bus_read(12'h00F, 8'h3C, "R1 R3 R4 R7 read back 0x00F");
        bus_read(12'h005, 8'h00, "R7 untouched reg");
    endtask

    task automatic t_undef();
        apply_mode(1'b1, 1'b1);
        bus_write(12'h003, 8'h77);
        bus_write(12'h123, 8'h5A);
        bus_read(12'h123, 8'h00, "R5 undefined reads zero");
        bus_read(12'h003, 8'h77, "R5 alias unchanged (R3 high bits)");
    endtask

    task automatic t_nocs();
        apply_mode(1'b0, 1'b0);
        bus_write(12'h003, 8'h77);
        @(negedge clk);
        apins = 12'h003; tb_ad = 8'hEE; tb_drv = 1'b1;
        rw_wr_n = 1'b0; ds_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        ds_rd_n = 1'b1; rw_wr_n = 1'b1; tb_drv = 1'b0;
        @(negedge clk);
        ds_rd_n = 1'b0;
        #1;
        chk("R11 R6 no drive without cs", ad, 8'hzz);
        @(negedge clk);
        set_idle();
        bus_read(12'h003, 8'h77, "R11 write without cs ignored");
    endtask

    task automatic t_overlap();
        apply_mode(1'b1, 1'b1);
        bus_write(12'h005, 8'h5F);
        start_addr(12'h00A);
        tb_ad = 8'hC3; tb_drv = 1'b1; rw_wr_n = 1'b0;
        repeat (W + 1) @(negedge clk);
        rw_wr_n = 1'b1; as_ale = 1'b1; tb_ad = 8'h05;
        @(negedge clk);
        as_ale = 1'b0; tb_drv = 1'b0; ds_rd_n = 1'b0;
        #1;
        chk("R4 R3 new address captured at commit edge", ad, 8'h5F);
        @(negedge clk);
        set_idle();
        bus_read(12'h00A, 8'hC3, "R4 commit used old address");
        bus_read(12'h005, 8'h5F, "R4 new address reg intact");
    endtask

    initial begin
        t_reset();
        t_mode(1'b0, 1'b0);
        t_mode(1'b0, 1'b1);
        t_mode(1'b1, 1'b0);
        t_mode(1'b1, 1'b1);
        t_undef();
        t_nocs();
        t_overlap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule